// File: doc/BRIEF.md
# Packed Parameter Float-to-Fixed Unpacker

This block sits in front of an on-chip parameter store. Software or a host link hands it 32-bit load words. Each word carries a storage address together with a compact 23-bit floating-point number. The block splits the word into its fields and restores the implied leading one of the significand. It then scales the result into an unsigned 31-bit fixed-point code with 4 fractional bits. The address, the code and a one-cycle write strobe go to the storage memory two clock cycles after the word is accepted.

The float layout has one sign bit, an 8-bit exponent biased by 127, and a 14-bit stored significand. The significand has an implied leading one, which gives 15 significant bits. There are no subnormals, no infinities and no NaN codes. The stored quantities are nonnegative, so a value with its sign bit set is flagged as an error and written as zero. Values that do not fit in the output saturate to the largest code. Values smaller than one fractional step become zero.

Top module: `flt_param_unpack`

## Requirements
- R1: The load word is split as follows: bits 31:23 are the storage address, bit 22 is the sign, bits 21:14 are the biased exponent and bits 13:0 are the stored significand.
- R2: For each cycle in which `load_valid` is high, `wr_en` is high for exactly one cycle, two rising edges later. `wr_en` is never high otherwise. Words may arrive on every cycle.
- R3: `wr_addr` carries bits 31:23 of the word that produced the current strobe, without change.
- R4: For a nonnegative word with exponent field e in 1..255, the code is floor((16384 + m) * 2^(e - 137)), where m is the significand field. The code has 4 fractional bits.
- R5: An exponent field of zero with the sign clear gives a code of zero, whatever the significand holds.
- R6: A nonnegative word whose exact code exceeds 2^31 - 1 gives 0x7FFFFFFF. This covers every exponent field from 154 to 255.
- R7: A nonnegative word whose scaled value is below one fractional step gives zero. This covers every exponent field from 1 to 122. Fractional remainders are truncated.
- R8: A word with the sign bit set gives a code of zero, and `neg_err` is high during its strobe. `neg_err` is low with every strobe of a nonnegative word and whenever `wr_en` is low.
- R9: While `rst_n` is low, `wr_en` and `neg_err` are low and `wr_addr` and `wr_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | The load word is valid in this cycle |
| load_word | input | 32 | Packed address and 23-bit float |
| wr_en | output | 1 | Write strobe to the parameter store |
| wr_addr | output | 9 | Storage address for the write |
| wr_data | output | 31 | Unsigned fixed-point code, 4 fractional bits |
| neg_err | output | 1 | The written word had its sign bit set |

## Verification
If the decode stage holds a wrong class or exponent, the fault shows on `wr_data` or `neg_err` in the strobe that immediately follows, one cycle after the decode register is loaded. The shift offset is exposed by exact powers of two and by both ends of the usable exponent range. If the valid bit is lost or left stuck in either stage, a strobe goes missing or an extra one appears. The reference model compares the strobe on every cycle, so such an error is caught in the cycle it happens. A wrong address path shows as a mismatched `wr_addr` when the address is all zeros or all ones.

// File: rtl/flt_unpack_pkg.sv
package flt_unpack_pkg;
  // Outcome of decoding one packed float
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NEG  = 2'd1,
    CLS_NORM = 2'd2
  } fcls_e;
endpackage

// File: rtl/flt_field_decode.sv
module flt_field_decode
  import flt_unpack_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 14,
  localparam int WORD_W = ADDR_W + 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output fcls_e             out_cls,
  output logic [EXP_W-1:0]  out_exp,
  output logic [MAN_W:0]    out_sig
);
  localparam int SIGN_POS = EXP_W + MAN_W;

  function automatic fcls_e classify(input logic sgn, input logic [EXP_W-1:0] e);
    if (sgn)            return CLS_NEG;
    else if (e == '0)   return CLS_ZERO;
    else                return CLS_NORM;
  endfunction

  logic              f_sign;
  logic [EXP_W-1:0]  f_exp;
  logic [MAN_W-1:0]  f_man;
  logic [ADDR_W-1:0] f_addr;

  assign f_addr = in_word[WORD_W-1 -: ADDR_W];
  assign f_sign = in_word[SIGN_POS];
  assign f_exp  = in_word[SIGN_POS-1 -: EXP_W];
  assign f_man  = in_word[MAN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_cls   <= CLS_ZERO;
      out_exp   <= '0;
      out_sig   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= f_addr;
        out_cls  <= classify(f_sign, f_exp);
        out_exp  <= f_exp;
        out_sig  <= {1'b1, f_man};
      end
    end
  end
endmodule

// File: rtl/flt_sig_scale.sv
module flt_sig_scale
  import flt_unpack_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 14,
  parameter int BIAS   = 127,
  parameter int FIX_W  = 31,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  fcls_e             in_cls,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MAN_W:0]    in_sig,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [FIX_W-1:0]  wr_data,
  output logic              neg_err
);
  localparam int PAD    = FIX_W - MAN_W - 1;
  localparam int SH_OFS = BIAS + MAN_W - FRAC_W;
  localparam int SH_MAX = FIX_W - MAN_W - 1;
  localparam logic [FIX_W-1:0] CODE_MAX = {FIX_W{1'b1}};

  function automatic logic [FIX_W-1:0] scale_sig(input logic [EXP_W-1:0] e,
                                                 input logic [MAN_W:0] sig);
    int sh;
    logic [FIX_W-1:0] ext;
    sh  = int'(e) - SH_OFS;
    ext = {{PAD{1'b0}}, sig};
    if (sh > SH_MAX)        return CODE_MAX;
    else if (sh >= 0)       return ext << sh;
    else if (-sh > MAN_W)   return '0;
    else                    return ext >> (-sh);
  endfunction

  logic [FIX_W-1:0] code_nx;
  always_comb begin
    code_nx = '0;
    if (in_cls == CLS_NORM) code_nx = scale_sig(in_exp, in_sig);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      neg_err <= 1'b0;
    end else begin
      wr_en   <= in_valid;
      neg_err <= in_valid && (in_cls == CLS_NEG);
      if (in_valid) begin
        wr_addr <= in_addr;
        wr_data <= code_nx;
      end
    end
  end
endmodule

// File: rtl/flt_param_unpack.sv
module flt_param_unpack
  import flt_unpack_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 14,
  parameter int BIAS   = 127,
  parameter int FIX_W  = 31,
  parameter int FRAC_W = 4,
  localparam int WORD_W = ADDR_W + 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [WORD_W-1:0] load_word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [FIX_W-1:0]  wr_data,
  output logic              neg_err
);
  // Decode-stage events, named for the checker
  logic              dec_valid;
  logic [ADDR_W-1:0] dec_addr;
  fcls_e             dec_cls;
  logic [EXP_W-1:0]  dec_exp;
  logic [MAN_W:0]    dec_sig;

  flt_field_decode #(
    .ADDR_W(ADDR_W), .EXP_W(EXP_W), .MAN_W(MAN_W)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (load_valid),
    .in_word  (load_word),
    .out_valid(dec_valid),
    .out_addr (dec_addr),
    .out_cls  (dec_cls),
    .out_exp  (dec_exp),
    .out_sig  (dec_sig)
  );

  flt_sig_scale #(
    .ADDR_W(ADDR_W), .EXP_W(EXP_W), .MAN_W(MAN_W),
    .BIAS(BIAS), .FIX_W(FIX_W), .FRAC_W(FRAC_W)
  ) u_scale (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(dec_valid),
    .in_addr (dec_addr),
    .in_cls  (dec_cls),
    .in_exp  (dec_exp),
    .in_sig  (dec_sig),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .neg_err (neg_err)
  );
endmodule

// File: rtl/flt_unpack_chk.sv
module flt_unpack_chk
  import flt_unpack_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 14,
  parameter int BIAS   = 127,
  parameter int FIX_W  = 31,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_valid,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [FIX_W-1:0]  wr_data,
  input logic              neg_err,
  input logic              dec_valid,
  input logic [ADDR_W-1:0] dec_addr,
  input fcls_e             dec_cls,
  input logic [EXP_W-1:0]  dec_exp
);
  localparam int SAT_EXP = BIAS + MAN_W - FRAC_W + (FIX_W - MAN_W - 1) + 1;

  // R2
  strobe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> ##2 wr_en);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(dec_valid));

  // R3
  addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr == $past(dec_addr));

  // R8
  neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_err |-> (wr_en && wr_data == '0));

  // R5
  zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_cls == CLS_ZERO) |=> (wr_data == '0 && !neg_err));

  // R6
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_cls == CLS_NORM && int'(dec_exp) >= SAT_EXP)
      |=> wr_data == {FIX_W{1'b1}});
endmodule

bind flt_param_unpack flt_unpack_chk #(
  .ADDR_W(ADDR_W), .EXP_W(EXP_W), .MAN_W(MAN_W),
  .BIAS(BIAS), .FIX_W(FIX_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_valid(load_valid),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .neg_err   (neg_err),
  .dec_valid (dec_valid),
  .dec_addr  (dec_addr),
  .dec_cls   (dec_cls),
  .dec_exp   (dec_exp)
);

// File: tb/test_flt_param_unpack.sv
module test_flt_param_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic [31:0] load_word = '0;
  logic        wr_en;
  logic [8:0]  wr_addr;
  logic [30:0] wr_data;
  logic        neg_err;

  always #4 clk = ~clk;

  flt_param_unpack i_flt_param_unpack (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_word(load_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .neg_err(neg_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit mon_on = 0;

  typedef struct {
    bit          v;
    longint      d;
    int          a;
    bit          e;
    string       tag;
  } exp_t;

  exp_t s1, s2;

  // Behavioural model: R1 field split, R4..R8 value rules
  function automatic exp_t model(input bit v, input logic [31:0] w);
    exp_t r;
    int ex, sh;
    longint sig, x;
    r.v = v; r.a = int'(w >> 23); r.e = 0; r.d = 0; r.tag = "R4";
    ex  = int'((w >> 14) & 32'hFF);
    sig = 16384 + longint'(w & 32'h3FFF);
    if (w[22]) begin
      r.e = 1; r.tag = "R8";
    end else if (ex == 0) begin
      r.tag = "R5";
    end else begin
      sh = ex - 137;
      if (sh > 40) x = 64'sh7FFF_FFFF_FFFF;
      else if (sh >= 0) x = sig * (longint'(1) << sh);
      else if (-sh >= 40) x = 0;
      else x = sig / (longint'(1) << (-sh));
      if (x > 2147483647) begin r.d = 2147483647; r.tag = "R6"; end
      else begin r.d = x; if (x == 0) r.tag = "R7"; end
    end
    return r;
  endfunction

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = '{0, 0, 0, 0, "R2"};
      s2 = '{0, 0, 0, 0, "R2"};
    end else begin
      s2 = s1;
      s1 = model(load_valid, load_word);
    end
  end

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      check("R2 wr_en", longint'(wr_en), longint'(s2.v));
      if (s2.v) begin
        check({s2.tag, " wr_data"}, longint'(wr_data), s2.d);
        check("R3 wr_addr (R1 bits 31:23)", longint'(wr_addr), longint'(s2.a));
        check("R8 neg_err", longint'(neg_err), longint'(s2.e));
      end else begin
        check("R8 neg_err idle", longint'(neg_err), 0);
      end
    end
  end

  task automatic send(input int a, input bit s, input int e, input int m);
    @(negedge clk);
    load_valid = 1'b1;
    load_word  = {a[8:0], s, e[7:0], m[13:0]};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load_valid = 1'b0;
      load_word  = $urandom;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R9 reset state, with a word offered during reset
    load_valid = 1'b1; load_word = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R9 wr_en in reset", longint'(wr_en), 0);
    check("R9 neg_err in reset", longint'(neg_err), 0);
    check("R9 wr_data in reset", longint'(wr_data), 0);
    check("R9 wr_addr in reset", longint'(wr_addr), 0);
    load_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1; mon_on = 1;
    idle(2);
    // R4 exact powers and fractions
    send(0, 0, 137, 0);          // 1024.0 -> 16384
    send(511, 0, 127, 0);        // 1.0 -> 16
    send(5, 0, 126, 14'h2000);   // 0.75 -> 12
    send(6, 0, 123, 0);          // 1/16 -> 1
    idle(1);
    // R4 largest fitting / R6 saturation
    send(7, 0, 153, 14'h3FFF);
    send(8, 0, 154, 0);
    send(9, 0, 255, 14'h3FFF);
    // R7 below one step, R5 zero exponent
    send(10, 0, 122, 14'h3FFF);
    send(11, 0, 1, 14'h1234);
    send(12, 0, 0, 14'h3FFF);
    // R8 negative inputs
    send(13, 1, 130, 14'h0055);
    send(14, 1, 0, 0);
    send(15, 0, 140, 14'h0ABC);
    idle(3);
    // Random mix, with gaps
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else send(int'($urandom_range(0, 511)), bit'($urandom_range(0, 5) == 0),
                int'($urandom_range(110, 160)), int'($urandom_range(0, 16383)));
    end
    idle(4);
    finish_run();
  end
endmodule